// File: doc/BRIEF.md
# Keyed Configuration Index Port

This block implements a legacy configuration space that a host reaches through two adjacent addresses on a simple 8-bit I/O bus. The lower address is the index port and the upper one is the data port. A strap input picks which of two base addresses the pair answers at. The space stays closed until the host writes the entry key to the index port twice in a row. It closes again when the host writes the exit key to the index port.

While the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. Register numbers below 0x30 form a global area. This area holds the device-select register and the fixed identification bytes. Register numbers from 0x30 upward belong to the device picked by the select register. They are forwarded to that device's register file, which sits outside this block. A parameter mask lists which device numbers are implemented.

The access-key state machine has three states. `ST_LOCKED` is the state after reset. `ST_KEY_HALF` means one entry key has been seen. `ST_OPEN` means configuration mode is active. Its transitions are:

- `enter_first`: from `ST_LOCKED` to `ST_KEY_HALF` on an index write of 0x87.
- `enter_second`: from `ST_KEY_HALF` to `ST_OPEN` on an index write of 0x87.
- `restart`: from `ST_KEY_HALF` back to `ST_LOCKED` on any other index write.
- `exit_key`: from `ST_OPEN` to `ST_LOCKED` on an index write of 0xAA.

In every other case the state holds.

Top module: `cfg_index_port`

## Requirements
- R1: The index port is at the base address and the data port at base+1. The base is 0x2E when `strap_alt` is 0 and 0x4E when it is 1. Writes to any other address have no effect, and reads from them return 0xFF.
- R2: Configuration mode opens only after two back-to-back index-port writes of 0x87.
- R3: An index-port write of 0xAA while open closes configuration mode. The value 0xAA is not stored as an index.
- R4: While not open, reads of both ports return 0xFF. Data-port writes change nothing. Index-port writes only advance or reset the key sequence.
- R5: While open, an index-port write of any value other than 0xAA is stored, and an index-port read returns the stored index.
- R6: While open, data reads return the device ID at 0x20 (high byte) and 0x21 (low byte), the revision at 0x22, and the vendor ID 0x1934 at 0x23 (0x19) and 0x24 (0x34). Other global indices below 0x30, apart from 0x07, read 0x00. Data writes to the identification indices leave them unchanged.
- R7: Index 0x07 holds the 8-bit device select, which can be written and read back through the data port while open.
- R8: After the first 0x87, any index-port write of a different value returns the key sequence to its start.
- R9: While open, data accesses at indices 0x30 and up go to the selected device. A write drives a one-cycle `ld_wr` with `ld_sel`, `ld_idx` and `ld_wdata`. A read returns `ld_rdata`. A device number that is not implemented reads 0x00 and never receives `ld_wr`.
- R10: After reset the port is locked, and the index and the device select are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base address choice: 0 selects 0x2E, 1 selects 0x4E |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address and the strobe |
| ld_sel | output | 8 | Selected device number |
| ld_idx | output | 8 | Current register index, passed to the device |
| ld_wr | output | 1 | Forwarded write pulse to the selected device |
| ld_wdata | output | 8 | Forwarded write data |
| ld_rdata | input | 8 | Read data from the selected device |

## Verification
The bench sweeps every possible byte as the middle write of a key sequence, so any stray value must reset the count. A design that only reset on the exit key, or that counted two keys that were not adjacent, would open when it should not. It then reads every global index and checks the identification bytes and the zero fill: a design that swapped the byte order or exposed the select register elsewhere would show a wrong value. It walks the select through implemented, unimplemented and out-of-range device numbers while counting forwarded write pulses, so a leak to a missing device is caught. Finally it checks that a locked port neither accepts data writes nor stores an index, and that the strap moves both ports together.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_ENTER    = 8'h87;
    localparam logic [7:0] KEY_EXIT     = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL   = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO = 8'h21;
    localparam logic [7:0] IDX_REV      = 8'h22;
    localparam logic [7:0] IDX_VEND_HI  = 8'h23;
    localparam logic [7:0] IDX_VEND_LO  = 8'h24;
    localparam logic [7:0] IDX_FWD_BASE = 8'h30;
    localparam logic [7:0] BUS_IDLE     = 8'hFF;

endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);

    key_state_e state_q, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_nx;
    end

    // Transitions: enter_first, enter_second, restart, exit_key
    always_comb begin
        state_nx = state_q;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED:   if (wdata == KEY_ENTER) state_nx = ST_KEY_HALF;
                ST_KEY_HALF: state_nx = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
                ST_OPEN:     if (wdata == KEY_EXIT) state_nx = ST_LOCKED;
                default:     state_nx = ST_LOCKED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unlocked = (state_q == ST_OPEN);
    end

    // R2: opening is only ever reached from the half-keyed state
    a_r2_open_from_half: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |-> $past(state_q) == ST_KEY_HALF);

    // R3: exit key closes the space
    a_r3_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && idx_wr && wdata == KEY_EXIT) |=> !unlocked);

    // R8: a non-key write while half-keyed restarts the sequence
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY_HALF && idx_wr && wdata != KEY_ENTER) |=> state_q == ST_LOCKED);

    // R4: with no index write the state holds
    a_r4_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(state_q));

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID    = 16'h1010,
    parameter logic [7:0]  REV       = 8'h01,
    parameter logic [15:0] VENDOR_ID = 16'h1934,
    parameter int          LD_COUNT  = 16,
    parameter logic [LD_COUNT-1:0] LD_MASK = LD_COUNT'(1 << 6)
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unlocked,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] ld_rdata,
    output logic [7:0] index_q,
    output logic [7:0] sel_q,
    output logic [7:0] dat_rdata,
    output logic       ld_wr
);

    localparam int LDW = (LD_COUNT > 1) ? $clog2(LD_COUNT) : 1;

    logic [LD_COUNT-1:0] present_vec;
    logic                sel_in_range;
    logic                ld_present;
    logic                fwd;

    for (genvar g = 0; g < LD_COUNT; g++) begin : g_present
        assign present_vec[g] = LD_MASK[g];
    end

    assign sel_in_range = (32'(sel_q) < LD_COUNT);
    assign ld_present   = sel_in_range && present_vec[sel_q[LDW-1:0]];
    assign fwd          = (index_q >= IDX_FWD_BASE);
    assign ld_wr        = unlocked && dat_wr && fwd && ld_present;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            sel_q   <= 8'h00;
        end else begin
            if (unlocked && idx_wr && wdata != KEY_EXIT) index_q <= wdata;
            if (unlocked && dat_wr && index_q == IDX_DEVSEL) sel_q <= wdata;
        end
    end

    always_comb begin
        if (fwd) begin
            dat_rdata = ld_present ? ld_rdata : 8'h00;
        end else begin
            unique case (index_q)
                IDX_DEVSEL:   dat_rdata = sel_q;
                IDX_DEVID_HI: dat_rdata = DEV_ID[15:8];
                IDX_DEVID_LO: dat_rdata = DEV_ID[7:0];
                IDX_REV:      dat_rdata = REV;
                IDX_VEND_HI:  dat_rdata = VENDOR_ID[15:8];
                IDX_VEND_LO:  dat_rdata = VENDOR_ID[7:0];
                default:      dat_rdata = 8'h00;
            endcase
        end
    end

    // R7: select changes only through an open data write
    a_r7_sel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && dat_wr) |=> $stable(sel_q));

    // R5: index changes only through an open index write
    a_r5_index_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && idx_wr) |=> $stable(index_q));

    // R3: the exit key never lands in the index register
    a_r3_exit_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wdata == KEY_EXIT) |=> $stable(index_q));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = ADDR_W'(16'h002E),
    parameter logic [ADDR_W-1:0] BASE_ALT = ADDR_W'(16'h004E),
    parameter logic [15:0] DEV_ID    = 16'h1010,
    parameter logic [7:0]  REV       = 8'h01,
    parameter logic [15:0] VENDOR_ID = 16'h1934,
    parameter int          LD_COUNT  = 16,
    parameter logic [LD_COUNT-1:0] LD_MASK = LD_COUNT'(1 << 6)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        ld_sel,
    output logic [7:0]        ld_idx,
    output logic              ld_wr,
    output logic [7:0]        ld_wdata,
    input  logic [7:0]        ld_rdata
);

    logic [ADDR_W-1:0] base;
    logic              hit_idx, hit_dat;
    logic              idx_wr, dat_wr;
    logic              unlocked;
    logic [7:0]        index_q, sel_q, dat_rdata;

    assign base    = strap_alt ? BASE_ALT : BASE_PRI;
    assign hit_idx = (bus_addr == base);
    assign hit_dat = (bus_addr == base + ADDR_W'(1));
    assign idx_wr  = bus_wr && hit_idx;
    assign dat_wr  = bus_wr && hit_dat;

    cfgp_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    cfgp_regfile #(
        .DEV_ID    (DEV_ID),
        .REV       (REV),
        .VENDOR_ID (VENDOR_ID),
        .LD_COUNT  (LD_COUNT),
        .LD_MASK   (LD_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlocked  (unlocked),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (bus_wdata),
        .ld_rdata  (ld_rdata),
        .index_q   (index_q),
        .sel_q     (sel_q),
        .dat_rdata (dat_rdata),
        .ld_wr     (ld_wr)
    );

    always_comb begin
        if (bus_rd && unlocked && hit_idx)      bus_rdata = index_q;
        else if (bus_rd && unlocked && hit_dat) bus_rdata = dat_rdata;
        else                                    bus_rdata = BUS_IDLE;
    end

    assign ld_sel   = sel_q;
    assign ld_idx   = index_q;
    assign ld_wdata = bus_wdata;

    // R4: a closed port reads as idle
    a_r4_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unlocked) |-> bus_rdata == BUS_IDLE);

    // R9: forwarded writes only in the device area of an open port
    a_r9_fwd_area: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |-> (unlocked && ld_idx >= IDX_FWD_BASE && bus_wr));

    // R1: addresses outside the pair read as idle
    a_r1_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_idx && !hit_dat) |-> bus_rdata == BUS_IDLE);

endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] T_DEV  = 16'h0814;
    localparam logic [7:0]  T_REV  = 8'h03;
    localparam logic [15:0] T_MASK = 16'h0145;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  ld_sel, ld_idx, ld_wdata, ld_rdata;
    logic        ld_wr;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int exp_wr_cnt = 0;
    logic [7:0] last_sel, last_idx, last_wd;

    // model state: 0 locked, 1 half key, 2 open
    int         m_st = 0;
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_sel = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ld_rdata = (ld_sel * 8'h11) ^ ld_idx;

    cfg_index_port #(
        .DEV_ID  (T_DEV),
        .REV     (T_REV),
        .LD_MASK (T_MASK)
    ) u_cfg_index_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ld_sel    (ld_sel),
        .ld_idx    (ld_idx),
        .ld_wr     (ld_wr),
        .ld_wdata  (ld_wdata),
        .ld_rdata  (ld_rdata)
    );

    always @(posedge clk) begin
        if (ld_wr) begin
            wr_cnt++;
            last_sel = ld_sel;
            last_idx = ld_idx;
            last_wd  = ld_wdata;
        end
    end

    function automatic logic [15:0] cur_base();
        return strap_alt ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic present(logic [7:0] s);
        return (s < 8'd16) && T_MASK[s[3:0]];
    endfunction

    function automatic logic [7:0] exp_data();
        if (m_idx >= 8'h30) return present(m_sel) ? ((m_sel * 8'h11) ^ m_idx) : 8'h00;
        case (m_idx)
            8'h07: return m_sel;
            8'h20: return T_DEV[15:8];
            8'h21: return T_DEV[7:0];
            8'h22: return T_REV;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        if (m_st == 2 && a == cur_base())            return m_idx;
        if (m_st == 2 && a == cur_base() + 16'd1)    return exp_data();
        return 8'hFF;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_idx = 8'h00; m_sel = 8'h00;
    endtask

    task automatic bw(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == cur_base()) begin
            case (m_st)
                0: if (d == 8'h87) m_st = 1;
                1: m_st = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_st = 0; else m_idx = d;
            endcase
        end else if (a == cur_base() + 16'd1 && m_st == 2) begin
            if (m_idx == 8'h07) m_sel = d;
            if (m_idx >= 8'h30 && present(m_sel)) exp_wr_cnt++;
        end
    endtask

    task automatic rd_check(string req, logic [15:0] a);
        logic [7:0] got;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 got = bus_rdata;
        bus_rd = 1'b0;
        check(req, got, exp_read(a));
    endtask

    task automatic unlock(logic [15:0] b);
        bw(b, 8'hAA); bw(b, 8'h87); bw(b, 8'h87);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R10 / R4: locked after reset, both bases read idle
        rd_check("R10", 16'h002E);
        rd_check("R10", 16'h002F);
        rd_check("R4",  16'h004E);
        // R10: index and select are zero once opened
        unlock(16'h002E);
        check("R10", {6'b0, 2'(m_st)}, 8'd2);
        rd_check("R10", 16'h002E);
        bw(16'h002E, 8'h07);
        rd_check("R10", 16'h002F);

        // R8 / R2: every byte as the interrupting write
        for (int v = 0; v < 256; v++) begin
            bw(16'h002E, 8'hAA); bw(16'h002E, 8'h87);
            bw(16'h002E, 8'(v)); bw(16'h002E, 8'h87);
            rd_check("R8", 16'h002E);
            bw(16'h002E, 8'h87);
            rd_check("R2", 16'h002E);
        end

        // R6 / R7: every global index
        unlock(16'h002E);
        for (int i = 0; i < 8'h30; i++) begin
            bw(16'h002E, 8'(i));
            rd_check((i == 7) ? "R7" : "R6", 16'h002F);
        end
        for (int i = 8'h20; i <= 8'h24; i++) begin
            bw(16'h002E, 8'(i)); bw(16'h002F, 8'h5A);
            rd_check("R6", 16'h002F);
        end

        // R7 / R9: walk device select
        for (int s = 0; s < 19; s++) begin
            logic [7:0] sv;
            sv = (s == 18) ? 8'h40 : 8'(s);
            bw(16'h002E, 8'h07); bw(16'h002F, sv);
            rd_check("R7", 16'h002F);
            bw(16'h002E, 8'h30 + 8'(s));
            rd_check("R9", 16'h002F);
            bw(16'h002E, 8'hFF);
            rd_check("R9", 16'h002F);
            bw(16'h002F, 8'hC3 ^ sv);
            check("R9", 8'(wr_cnt), 8'(exp_wr_cnt));
            if (present(sv)) begin
                check("R9", last_sel, sv);
                check("R9", last_idx, 8'hFF);
                check("R9", last_wd, 8'hC3 ^ sv);
            end
        end

        // R5: index register readback
        for (int i = 0; i < 256; i += 17) begin
            bw(16'h002E, 8'(i));
            rd_check("R5", 16'h002E);
        end

        // R3: exit key closes and is not stored
        bw(16'h002E, 8'h07); bw(16'h002F, 8'h06);
        bw(16'h002E, 8'hAA);
        rd_check("R3", 16'h002E);
        rd_check("R3", 16'h002F);

        // R4: locked writes ignored
        bw(16'h002E, 8'h22);
        bw(16'h002F, 8'h09);
        bw(16'h002E, 8'h87); bw(16'h002E, 8'h87);
        rd_check("R4", 16'h002E);
        bw(16'h002E, 8'h07);
        rd_check("R4", 16'h002F);

        // R1: strap moves the pair, other addresses miss
        strap_alt = 1'b1;
        bw(16'h002E, 8'hAA);
        rd_check("R1", 16'h004E);
        unlock(16'h004E);
        rd_check("R1", 16'h004E);
        rd_check("R1", 16'h004F);
        rd_check("R1", 16'h002E);
        rd_check("R1", 16'h0050);
        bw(16'h002F, 8'h33);
        rd_check("R1", 16'h004F);

        // R10: reset while open
        do_reset();
        rd_check("R10", 16'h004E);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule